// File: doc/BRIEF.md
# I2C Slave Register File

This block is an I2C slave front end for a 64-byte register and RAM space. The storage sits inside the block. SCL and SDA arrive as raw pins and are oversampled on the system clock. The block finds START, repeated START and STOP. It compares the 7-bit device address and then serves write or read transfers. It answers by pulling SDA low through an open-drain enable. A volatile 6-bit word pointer selects the byte.

In a write transfer, the first byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then advances on that byte's acknowledge clock. A read transfer sends the byte at the pointer. The pointer advances only when the master acknowledges a byte. A read that follows a pointer write and a repeated START is a random read. A read with no pointer write resumes where the pointer last stood. A write-inhibit input shuts off all access to the storage.

A local host port reads and writes the same storage. It uses a valid/ready handshake. A request is taken on a clock edge where `host_valid` and `host_ready` are both high. The host must hold the request stable while `host_ready` is low. `host_ready` is low while write-inhibit is asserted. It is also low in the single cycle in which the bus side writes a byte, because bus writes have priority. Read data comes back one cycle after acceptance, marked by `host_rvalid`. The read return has no back-pressure.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and `host_ready` is 1 (with inhibit low). The word pointer is 0, so a read without a pointer write returns the byte at address 0.
- R2: The slave acknowledges its address, by driving SDA low in the ninth clock, when the first byte after START carries the device address (default 7'h68) in bits 7..1. Bit 0 of that byte is the direction: 0 for write, 1 for read.
- R3: An address that does not match gets no acknowledge. Until the next START or STOP, the slave then acknowledges nothing and stores nothing, and the pointer keeps its value.
- R4: In a write transfer, the first byte loads bits 5..0 into the pointer. Each later byte is acknowledged and stored at the pointer. The pointer then increments, wrapping from 63 to 0.
- R5: A random read returns the byte at the loaded pointer and then consecutive bytes, wrapping from 63 to 0, for as long as the master acknowledges.
- R6: A read with no pointer write starts at the current pointer. A byte the master does not acknowledge does not advance the pointer.
- R7: After a master not-acknowledge, the slave keeps SDA released until the next START, so further clocks read 8'hFF.
- R8: `sda_oe` changes only while SCL is low.
- R9: While `wr_inhibit` is 1, the device address gets no acknowledge and `host_ready` is 0. The storage and the pointer are left unchanged.
- R10: The host port writes `host_wdata` to `host_addr` when a write is accepted. After an accepted read, `host_rvalid` is 1 for one cycle with the byte at `host_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_inhibit | input | 1 | Blocks all storage access and address acknowledge |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted when high with valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 8 | Host read data |

## Verification
Most wrong internal state shows at the ports within one bus byte.

- **Bit counter or address comparison:** a fault moves or drops the acknowledge in the ninth clock of that byte.
- **Pointer:** a pointer that advances on the wrong event, fails to wrap or ignores a not-acknowledge stays hidden until a later read. That read then returns the byte from a neighbouring address.
- **Write path:** a bad write path is seen only when the host port or the bus reads that address back.

The sweeps therefore write every address and read it back across the wrap, and follow each ignored or inhibited transfer with a current-address read.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_MACK
  } eng_state_t;

  typedef enum logic [1:0] {
    K_DEV, K_PTR, K_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rf_store.sv
module i2c_rf_store #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_data,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (b_re) b_data <= mem[b_addr];
  end

  assign a_data = mem[a_addr];
endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         AW       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              inhibit,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [AW-1:0]     ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  eng_state_t        state;
  byte_kind_t        kind;
  logic              rw, full, inc_on_ack, mack;
  logic [2:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx_byte;

  assign tx_byte = inhibit ? '1 : mem_rdata;
  assign wr_en   = (state == S_RX) && scl_fall && full && (kind == K_DATA)
                   && !inhibit && !start_det && !stop_det;
  assign wr_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; kind <= K_DEV; rw <= 1'b0; full <= 1'b0;
      inc_on_ack <= 1'b0; mack <= 1'b0; bitcnt <= '0; shreg <= '0;
      ptr <= '0; sda_oe <= 1'b0;
    end else if (start_det) begin
      state <= S_RX; kind <= K_DEV; bitcnt <= '0; full <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      state <= S_IDLE; full <= 1'b0; sda_oe <= 1'b0;
    end else begin
      unique case (state)
        S_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            full   <= (bitcnt == 3'd7);
          end else if (scl_fall && full) begin
            full       <= 1'b0;
            inc_on_ack <= 1'b0;
            unique case (kind)
              K_DEV: begin
                if (shreg[7:1] == DEV_ADDR && !inhibit) begin
                  rw <= shreg[0]; sda_oe <= 1'b1; state <= S_ACK;
                end else state <= S_IDLE;
              end
              K_PTR: begin
                if (!inhibit) begin
                  ptr <= shreg[AW-1:0]; sda_oe <= 1'b1; state <= S_ACK;
                end else state <= S_IDLE;
              end
              default: begin
                if (!inhibit) begin
                  inc_on_ack <= 1'b1; sda_oe <= 1'b1; state <= S_ACK;
                end else state <= S_IDLE;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_rise && inc_on_ack) ptr <= ptr + 1'b1;
          if (scl_fall) begin
            bitcnt     <= '0;
            inc_on_ack <= 1'b0;
            if (kind == K_DEV && rw) begin
              state <= S_TX; shreg <= tx_byte; sda_oe <= ~tx_byte[7];
            end else begin
              state  <= S_RX; sda_oe <= 1'b0;
              kind   <= (kind == K_DEV) ? K_PTR : K_DATA;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              state <= S_MACK; sda_oe <= 1'b0;
            end else begin
              shreg  <= {shreg[BYTE_W-2:0], 1'b1};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 3'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
            if (!sda_s) ptr <= ptr + 1'b1;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (mack) begin
              state <= S_TX; shreg <= tx_byte; sda_oe <= ~tx_byte[7];
            end else state <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  // R8: the enable changes only in a cycle that follows a low SCL sample
  p_sda_low_scl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
  // R3: an address acknowledge only follows a matching, uninhibited address
  p_ack_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && $past(state) == S_RX && $past(kind) == K_DEV)
      |-> ($past(shreg[7:1]) == DEV_ADDR && !$past(inhibit)));
  // R4: the pointer moves only on an SCL rise or on a word-address load
  p_ptr_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ($past(scl_rise) || $past(state == S_RX && kind == K_PTR)));
  // R7: a START always leaves SDA released
  p_start_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> !sda_oe);
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         AW          = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              wr_inhibit,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic              host_rvalid,
  output logic [BYTE_W-1:0] host_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0]     ptr;
  logic              eng_we, mem_we, host_fire;
  logic [BYTE_W-1:0] eng_wdata, mem_wdata, a_data;
  logic [AW-1:0]     mem_waddr;

  i2c_bus_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2c_rf_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .inhibit(wr_inhibit), .mem_rdata(a_data),
    .ptr(ptr), .wr_en(eng_we), .wr_data(eng_wdata), .sda_oe(sda_oe));

  assign host_ready = !wr_inhibit && !eng_we;
  assign host_fire  = host_valid && host_ready;
  assign mem_we     = eng_we || (host_fire && host_we);
  assign mem_waddr  = eng_we ? ptr : host_addr;
  assign mem_wdata  = eng_we ? eng_wdata : host_wdata;

  i2c_rf_store #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .a_addr(ptr), .a_data(a_data),
    .b_re(host_fire && !host_we), .b_addr(host_addr), .b_data(host_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rvalid <= 1'b0;
    else        host_rvalid <= host_fire && !host_we;
  end

  // R9: no storage write while inhibited
  p_no_write_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wr_inhibit);
  // R10: read data valid only one cycle after an accepted read
  p_rvalid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_valid && !host_we && !wr_inhibit));
endmodule

// File: tb/sim_i2c_regfile_slave.sv
module sim_i2c_regfile_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda_low = 1'b0;
  logic sda_oe, wr_inhibit = 1'b0;
  logic host_valid = 1'b0, host_ready, host_we = 1'b0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic host_rvalid;
  logic sda_line;

  int checks = 0, errors = 0, r8_viol = 0;
  logic [7:0] exp_mem [64];
  logic done = 1'b0;

  assign sda_line = !(m_sda_low || sda_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regfile_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .wr_inhibit(wr_inhibit), .host_valid(host_valid), .host_ready(host_ready),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata));

  logic oe_q = 1'b0;
  always @(posedge clk) begin
    if (rst_n && m_scl && (sda_oe != oe_q)) r8_viol++;
    oe_q <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    m_sda_low = 0; w(H); m_scl = 1; w(H); m_sda_low = 1; w(H); m_scl = 0; w(H);
  endtask

  task automatic i2c_stop;
    m_sda_low = 1; w(H); m_scl = 1; w(H); m_sda_low = 0; w(H);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i]; w(H); m_scl = 1; w(H); m_scl = 0;
    end
    m_sda_low = 0; w(H); m_scl = 1; w(H/2); acked = (sda_line == 0); w(H/2); m_scl = 0;
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] b);
    m_sda_low = 0;
    for (int i = 7; i >= 0; i--) begin
      w(H); m_scl = 1; w(H/2); b[i] = sda_line; w(H/2); m_scl = 0;
    end
    m_sda_low = give_ack; w(H); m_scl = 1; w(H); m_scl = 0; w(2); m_sda_low = 0;
  endtask

  task automatic host_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); host_valid = 1; host_we = 1; host_addr = a; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(negedge clk); host_valid = 0; host_we = 0;
  endtask

  task automatic host_rd(input logic [5:0] a, output logic [7:0] d, output bit v);
    @(negedge clk); host_valid = 1; host_we = 0; host_addr = a;
    while (!host_ready) @(negedge clk);
    @(negedge clk); host_valid = 0; v = host_rvalid; d = host_rdata;
  endtask

  // current-address read of n bytes, last one not acknowledged
  task automatic cur_read(input int n, input int start, input string req);
    bit a; logic [7:0] b;
    i2c_start; wbyte(8'hD1, a);
    chk(a, "R2", a, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n-1, b);
      chk(b == exp_mem[(start+i)%64], req, b, exp_mem[(start+i)%64]);
    end
    i2c_stop;
  endtask

  initial begin
    bit a, v; logic [7:0] b;
    w(5);
    chk(sda_oe == 0 && host_ready == 1 && host_rvalid == 0, "R1", sda_oe, 0);
    rst_n = 1; w(5);
    chk(sda_oe == 0 && host_ready == 1, "R1", host_ready, 1);

    host_wr(6'd0, 8'h3C); exp_mem[0] = 8'h3C;
    host_rd(6'd0, b, v);
    chk(v && b == 8'h3C, "R10", b, 8'h3C);
    cur_read(1, 0, "R1");

    // full write sweep from pointer 0
    i2c_start; wbyte(8'hD0, a); chk(a, "R2", a, 1);
    wbyte(8'h00, a); chk(a, "R4", a, 1);
    for (int i = 0; i < 64; i++) begin
      exp_mem[i] = 8'((i * 37 + 5) & 8'hFF);
      wbyte(exp_mem[i], a); chk(a, "R4", a, 1);
    end
    i2c_stop;
    for (int i = 0; i < 64; i += 7) begin
      host_rd(6'(i), b, v); chk(v && b == exp_mem[i], "R10", b, exp_mem[i]);
    end

    // wrap write 62,63,0,1 -> pointer 2
    i2c_start; wbyte(8'hD0, a); wbyte(8'd62, a); chk(a, "R4", a, 1);
    for (int i = 0; i < 4; i++) begin
      exp_mem[(62+i)%64] = 8'hA0 + 8'(i); wbyte(8'hA0 + 8'(i), a);
    end
    i2c_stop;

    // current read resumes at 2; nacked byte does not advance
    cur_read(3, 2, "R6");
    cur_read(1, 4, "R6");

    // random read all 64 from 10 with wrap; pointer ends at 9
    i2c_start; wbyte(8'hD0, a); wbyte(8'd10, a);
    i2c_start; wbyte(8'hD1, a); chk(a, "R5", a, 1);
    for (int i = 0; i < 64; i++) begin
      rbyte(i != 63, b); chk(b == exp_mem[(10+i)%64], "R5", b, exp_mem[(10+i)%64]);
    end
    // after nack, slave stays released
    rbyte(0, b); chk(b == 8'hFF, "R7", b, 8'hFF);
    i2c_stop;

    // mismatched address ignored
    i2c_start; wbyte(8'hD2, a); chk(!a, "R3", a, 0);
    wbyte(8'h05, a); chk(!a, "R3", a, 0);
    wbyte(8'hEE, a); chk(!a, "R3", a, 0);
    i2c_stop;
    host_rd(6'd5, b, v); chk(b == exp_mem[5], "R3", b, exp_mem[5]);
    cur_read(1, 9, "R3");

    // inhibit
    wr_inhibit = 1; w(2);
    chk(!host_ready, "R9", host_ready, 0);
    i2c_start; wbyte(8'hD0, a); chk(!a, "R9", a, 0);
    wbyte(8'h20, a); wbyte(8'h55, a); i2c_stop;
    wr_inhibit = 0; w(2);
    host_rd(6'd32, b, v); chk(b == exp_mem[32], "R9", b, exp_mem[32]);
    cur_read(1, 9, "R9");

    chk(r8_viol == 0, "R8", r8_viol, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule